// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned n-bit number by another, producing one quotient bit per clock. It uses the classic subtract-then-restore method with a moving divisor. The divisor sits in a register twice the operand width. It starts in the upper half and moves one place toward the least significant end after each step. A matching double-width remainder register starts out holding the zero-extended dividend. Each step subtracts the divisor from the remainder whatever their sizes. If the difference goes negative, the divisor is added back and a 0 enters the quotient. Otherwise the difference is kept and a 1 enters the quotient.

A client raises `start` for one cycle with the operands valid while the block is idle. The block then stays `busy` for N+1 cycles. After that it pulses `done` for a single cycle. The quotient and remainder stay on the outputs until the next accepted start. There is no back-pressure on the result: `done` is a one-cycle notice, and the result stays readable at the outputs for as long as the client needs. A `start` seen while `busy` is high is dropped.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` reads high in the following cycle.
- R3: `done` goes high on the (N+1)th rising edge after the accepting edge, that is after exactly N+1 cycles of `busy`.
- R4: For a non-zero divisor, at `done` the outputs hold `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor, both unsigned N-bit values. For example, 7 / 2 gives 3 remainder 1.
- R5: For a zero divisor, the block finishes with normal timing and gives `quotient` with all N bits set and `remainder` equal to the dividend. No error indication is raised.
- R6: A `start` raised while `busy` is high has no effect: the running result uses only the operands captured at acceptance, and no extra `done` follows.
- R7: While the block is idle and `start` is low, `quotient` and `remainder` do not change, whatever the operand inputs do.
- R8: `done` lasts exactly one cycle and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; honoured only when idle |
| dividend | input | N | Unsigned dividend, sampled on the accepting edge |
| divisor | input | N | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | N | Unsigned quotient, held until the next accepted start |
| remainder | output | N | Unsigned remainder, held until the next accepted start |

## Verification
An operand pair is accepted on one edge. `busy` is due one cycle later, and `done` together with the result is due N+2 cycles after the cycle in which `start` was driven. The bench drives inputs on falling edges and stamps each expected item with that due cycle from a free-running cycle count. The monitor compares the quotient, remainder and arrival cycle against the stamp at the falling edge where `done` shows. The following falling edge must show `done` low again. Holding of the outputs is sampled over several idle cycles after the result, while the operand inputs are changed underneath.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  // number of subtract/restore steps for an n-bit operand
  function automatic int unsigned div_steps(input int unsigned n);
    return n + 1;
  endfunction

endpackage

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_cur,
  input  logic [W-1:0] dvs_cur,
  output logic [W-1:0] rem_nxt,
  output logic         q_bit
);
  // one extra bit so the borrow shows up as a clean sign
  logic [W:0]   diff_ext;
  logic         is_neg;
  logic [W-1:0] restored;

  always_comb begin
    diff_ext = {1'b0, rem_cur} - {1'b0, dvs_cur};
    is_neg   = diff_ext[W];
    restored = diff_ext[W-1:0] + dvs_cur;
    rem_nxt  = is_neg ? restored : diff_ext[W-1:0];
    q_bit    = ~is_neg;
  end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int STEPS = div_steps(N);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  div_state_e       state;
  logic [CNT_W-1:0] iter;

  assign load = (state == DIV_IDLE) && start;
  assign step = (state == DIV_RUN);
  assign busy = (state == DIV_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DIV_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        DIV_IDLE: begin
          if (start) begin
            state <= DIV_RUN;
            iter  <= '0;
          end
        end
        DIV_RUN: begin
          iter <= iter + 1'b1;
          if (iter == LAST) begin
            state <= DIV_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= DIV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  localparam int W = 2 * N;

  logic [W-1:0] rem_q;
  logic [W-1:0] dvs_q;
  logic [N-1:0] quo_q;
  logic [W-1:0] rem_d;
  logic         qbit;

  div_step #(.W(W)) u_step (
    .rem_cur (rem_q),
    .dvs_cur (dvs_q),
    .rem_nxt (rem_d),
    .q_bit   (qbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= {{N{1'b0}}, dividend};
      dvs_q <= {divisor, {N{1'b0}}};
      quo_q <= '0;
    end else if (step) begin
      rem_q <= rem_d;
      quo_q <= {quo_q[N-2:0], qbit};
      dvs_q <= dvs_q >> 1;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q[N-1:0];

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  logic load;
  logic step;

  div_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  div_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: rtl/div_chk.sv
module div_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N-1:0] dividend,
  input logic [N-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder
);
  logic [N-1:0] cap_a;
  logic [N-1:0] cap_b;
  int           run_cnt;
  logic         accept;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      run_cnt <= 0;
    end else if (accept) begin
      cap_a   <= dividend;
      cap_b   <= divisor;
      run_cnt <= 0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == N + 1));

  // R4
  result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b != '0) |-> (quotient == cap_a / cap_b && remainder == cap_a % cap_b));

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b == '0) |-> (quotient == {N{1'b1}} && remainder == cap_a));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

bind restoring_divider div_chk #(.N(N)) u_div_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/test_restoring_divider.sv
`timescale 1ns/1ps
module test_restoring_divider;
  localparam int N = 8;
  localparam int WDOG = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic [N-1:0] quotient;
  logic [N-1:0] remainder;

  restoring_divider #(.N(N)) i_restoring_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [N-1:0] q;
    logic [N-1:0] r;
    logic         zero_b;
    int           due;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   last_done = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (last_done)
        chk(!done, "R8 done longer than one cycle", int'(done), 0);
      if (done) begin
        chk(!busy, "R8 busy together with done", int'(busy), 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(quotient == e.q, e.zero_b ? "R5 quotient" : "R4 quotient",
              int'(quotient), int'(e.q));
          chk(remainder == e.r, e.zero_b ? "R5 remainder" : "R4 remainder",
              int'(remainder), int'(e.r));
          chk(cyc == e.due, "R3 done cycle", cyc, e.due);
        end
      end
      last_done = done;
    end
    if (cyc > WDOG && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", cyc, WDOG);
      summary();
    end
  end

  task automatic run_div(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start    = 1'b1;
    dividend = a;
    divisor  = b;
    e.zero_b = (b == '0);
    e.q      = (b == '0) ? {N{1'b1}} : a / b;
    e.r      = (b == '0) ? a : a % b;
    e.due    = cyc + N + 2;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      // R6: operands and start pulsed while running must be ignored
      dividend = ~a;
      divisor  = b + 8'd3;
      start    = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start    = 1'b0;
      dividend = 8'h5A;
      divisor  = 8'hC3;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done at reset", int'(done), 0);
    chk(quotient == '0, "R1 quotient at reset", int'(quotient), 0);
    chk(remainder == '0, "R1 remainder at reset", int'(remainder), 0);

    run_div(8'd7, 8'd2, 1'b0);
    run_div(8'd255, 8'd1, 1'b0);
    run_div(8'd0, 8'd5, 1'b0);
    run_div(8'd5, 8'd200, 1'b0);
    run_div(8'd255, 8'd255, 1'b0);
    run_div(8'd100, 8'd0, 1'b0);
    run_div(8'd0, 8'd0, 1'b0);
    run_div(8'd99, 8'd7, 1'b1);
    drain();
    @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R6 no extra run", int'(busy), 0);

    // R7 hold while idle with moving operand inputs
    run_div(8'd200, 8'd13, 1'b0);
    drain();
    for (int k = 0; k < 5; k++) begin
      dividend = dividend + 8'd37;
      divisor  = divisor ^ 8'h55;
      @(negedge clk);
      chk(quotient == 8'd15, "R7 quotient held", int'(quotient), 15);
      chk(remainder == 8'd5, "R7 remainder held", int'(remainder), 5);
    end

    for (int k = 0; k < 30; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_div(lfsr[7:0], (k % 7 == 3) ? 8'd0 : lfsr[15:8], (k % 5 == 0));
    end
    drain();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
  end

endmodule